// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

This block is an N by N grid of multiply-accumulate cells that multiplies a stream of activation vectors by a weight matrix held inside the grid. Each cell keeps one signed 8-bit weight. A signed 8-bit activation passes through the cell from left to right. The cell multiplies the activation by its weight and adds the product to a 16-bit partial sum that comes down from the cell above. The sum wraps on overflow. Each row of the bottom edge, once re-aligned, is one row of the product.

The weights are loaded first. While `wset` is high, one weight row per cycle enters the top edge and every cell hands its weight to the cell below it. A small load controller counts these shifts and reports when a complete matrix is in place. It has three states:

- `LD_EMPTY`: no weights loaded since reset.
- `LD_FILL`: a load is in progress, with a count of shifts so far.
- `LD_FULL`: a complete matrix is resident.

Its transitions are:

- EMPTY to FILL on the first shift.
- FILL to FILL on each further shift, and on idle cycles.
- FILL to FULL on the N-th shift.
- FULL to FILL when a shift starts a reload.

Activation vectors are accepted only in `LD_FULL`. Row k of each vector is delayed by k cycles before it enters the grid, and a valid bit travels with it. Column j of the result is delayed by N-1-j cycles on the way out, so that a whole result vector appears together under one strobe.

Top module: `wsa_array`

## Requirements
- R1: While `rst_n` is low, `out_vld`, `w_loaded` and every bit of `out_sum` are 0.
- R2: A cycle with `en`=1 and `wset`=1 is a shift. In a shift, each top-row cell takes its weight from `wt_in` (column j at bits [8j+7:8j]), and each cell in row r>0 takes the weight held by the cell above it. After N shifts, row r holds the row that was presented on shift number N-1-r, counting shifts from 0.
- R3: `w_loaded` is high only in `LD_FULL`. It rises after the N-th shift counted from reset or from `LD_FULL`. The first shift made in `LD_FULL` clears `w_loaded` and starts a new count at 1. A load left incomplete keeps its count across idle cycles.
- R4: An activation vector is taken only when `act_vld`=1, `en`=1, `wset`=0 and `w_loaded`=1 in that cycle. A vector presented under any other condition never produces an output vector.
- R5: For an accepted vector a, where row k sits at `act_in` bits [8k+7:8k], field j of `out_sum` (bits [16j+15:16j]) equals the sum over k of a[k]·W[k][j]. All values are signed two's complement, and W is the weight matrix resident when the vector is accepted.
- R6: The 16-bit sums wrap modulo 2^16 and never saturate.
- R7: A vector accepted at a clock edge appears on `out_sum` with `out_vld`=1 after the 2N-2-th following active edge. With N=4 that is 2N-1 = 7 cycles counting the accepting one. Every column of the vector appears in that same cycle.
- R8: With `en`=0, no register changes. This covers weights, controller state, skew stages and outputs, and all data inputs are ignored.
- R9: During a shift, the activation, valid and partial-sum registers hold, so `out_sum` and `out_vld` keep their values.
- R10: Vectors accepted on consecutive active cycles emerge on consecutive active cycles, in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global advance enable; low freezes the block |
| wset | input | 1 | Weight shift strobe; freezes the data pipeline |
| wt_in | input | N*8 | Weight row entering the top edge, column j at [8j+7:8j] |
| act_vld | input | 1 | Activation vector valid |
| act_in | input | N*8 | Activation vector, row k at [8k+7:8k] |
| w_loaded | output | 1 | A complete weight matrix is resident |
| out_vld | output | 1 | `out_sum` holds a new result vector |
| out_sum | output | N*16 | Result vector, column j at [16j+15:16j] |

## Verification
Two pairs of controls can collide in one cycle: a weight-shift request with the global enable low, and a weight shift with a valid activation vector. The random phase sometimes raises `wset` and `act_vld` while `en` is low. A correct design leaves both the weights and the load state unchanged, and later result vectors still match the product with the old matrix. Each weight load also drives random valid activations on every shift cycle. None of them may add a result vector, which shows up as an unexpected output or as a non-empty expected queue at the end.

// File: rtl/wsa_pkg.sv
`timescale 1ns/1ps
package wsa_pkg;

    // Weight-load controller states
    typedef enum logic [1:0] {
        LD_EMPTY = 2'd0,
        LD_FILL  = 2'd1,
        LD_FULL  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/wsa_delay.sv
`timescale 1ns/1ps
// Fixed-length delay line that advances only when adv is high.
// D = 0 gives a plain wire.
module wsa_delay #(
    parameter int W = 8,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (D == 0) begin : g_wire
            logic unused_ctl;
            assign unused_ctl = clk ^ rst_n ^ adv;
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] st [D];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < D; i++) st[i] <= '0;
                end else if (adv) begin
                    st[0] <= d;
                    for (int i = 1; i < D; i++) st[i] <= st[i-1];
                end
            end
            assign q = st[D-1];
        end
    endgenerate

endmodule

// File: rtl/wsa_pe.sv
`timescale 1ns/1ps
// One grid cell: a held weight, one signed multiply, one accumulate.
module wsa_pe #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wset,
    input  logic [DW-1:0] w_in,
    input  logic [DW-1:0] din,
    input  logic          vin,
    input  logic [AW-1:0] acc_in,
    output logic [DW-1:0] w_out,
    output logic [DW-1:0] d_out,
    output logic          v_out,
    output logic [AW-1:0] acc_out
);

    localparam int PW = 2 * DW;

    logic [DW-1:0]        w_q;
    logic [DW-1:0]        d_q;
    logic                 v_q;
    logic [AW-1:0]        acc_q;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    assign prod     = $signed(w_q) * $signed(din);
    assign prod_ext = AW'(prod);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q   <= '0;
            d_q   <= '0;
            v_q   <= 1'b0;
            acc_q <= '0;
        end else if (en) begin
            if (wset) begin
                w_q <= w_in;
            end else begin
                d_q   <= din;
                v_q   <= vin;
                acc_q <= vin ? (acc_in + prod_ext) : acc_in;
            end
        end
    end

    assign w_out   = w_q;
    assign d_out   = d_q;
    assign v_out   = v_q;
    assign acc_out = acc_q;

endmodule

// File: rtl/wsa_load_ctl.sv
`timescale 1ns/1ps
// Counts weight shifts and reports a complete resident matrix.
module wsa_load_ctl
    import wsa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wset,
    output logic w_loaded
);

    localparam int CW = $clog2(N + 1);

    ld_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          shift;

    assign shift = en & wset;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LD_EMPTY, LD_FULL: begin
                if (shift) begin
                    cnt_d   = CW'(1);
                    state_d = (N == 1) ? LD_FULL : LD_FILL;
                end
            end
            LD_FILL: begin
                if (shift) begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == CW'(N - 1)) state_d = LD_FULL;
                end
            end
            default: begin
                state_d = LD_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        w_loaded = (state_q == LD_FULL);
    end

endmodule

// File: rtl/wsa_array.sv
`timescale 1ns/1ps
// N x N weight-stationary multiply-accumulate grid with input skew,
// output de-skew and weight-load sequencing.
module wsa_array #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            wset,
    input  logic [N*DW-1:0] wt_in,
    input  logic            act_vld,
    input  logic [N*DW-1:0] act_in,
    output logic            w_loaded,
    output logic            out_vld,
    output logic [N*AW-1:0] out_sum
);

    localparam int SKW = DW + 1;   // valid + activation
    localparam int DSW = AW + 1;   // valid + sum

    logic adv;
    logic act_take;

    assign adv      = en & ~wset;
    assign act_take = act_vld & w_loaded;

    wsa_load_ctl #(.N(N)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .wset     (wset),
        .w_loaded (w_loaded)
    );

    logic [SKW-1:0] skew_q [N];
    logic [DW-1:0]  row_d  [N];
    logic           row_v  [N];

    logic [DW-1:0]  pe_din [N][N];
    logic           pe_vin [N][N];
    logic [DW-1:0]  pe_win [N][N];
    logic [AW-1:0]  pe_ain [N][N];
    logic [DW-1:0]  pe_d   [N][N];
    logic           pe_v   [N][N];
    logic [DW-1:0]  pe_w   [N][N];
    logic [AW-1:0]  pe_acc [N][N];

    logic [DSW-1:0] ds_q   [N];
    logic [N-1:0]   col_v;
    logic [N-1:0]   unused_right;
    logic [N-1:0]   unused_bottom;

    genvar k, j;
    generate
        // Row k enters k cycles late
        for (k = 0; k < N; k++) begin : g_skew
            wsa_delay #(.W(SKW), .D(k)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (adv),
                .d     ({act_take, act_in[k*DW +: DW]}),
                .q     (skew_q[k])
            );
            assign row_v[k] = skew_q[k][DW];
            assign row_d[k] = skew_q[k][DW-1:0];
            assign unused_right[k] = ^{pe_d[k][N-1], pe_v[k][N-1]};
        end

        for (k = 0; k < N; k++) begin : g_row
            for (j = 0; j < N; j++) begin : g_col
                if (j == 0) begin : g_left
                    assign pe_din[k][j] = row_d[k];
                    assign pe_vin[k][j] = row_v[k];
                end else begin : g_inner_h
                    assign pe_din[k][j] = pe_d[k][j-1];
                    assign pe_vin[k][j] = pe_v[k][j-1];
                end
                if (k == 0) begin : g_top
                    assign pe_win[k][j] = wt_in[j*DW +: DW];
                    assign pe_ain[k][j] = '0;
                end else begin : g_inner_v
                    assign pe_win[k][j] = pe_w[k-1][j];
                    assign pe_ain[k][j] = pe_acc[k-1][j];
                end
                wsa_pe #(.DW(DW), .AW(AW)) u_pe (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .en      (en),
                    .wset    (wset),
                    .w_in    (pe_win[k][j]),
                    .din     (pe_din[k][j]),
                    .vin     (pe_vin[k][j]),
                    .acc_in  (pe_ain[k][j]),
                    .w_out   (pe_w[k][j]),
                    .d_out   (pe_d[k][j]),
                    .v_out   (pe_v[k][j]),
                    .acc_out (pe_acc[k][j])
                );
            end
        end

        // Column j leaves N-1-j cycles late so all columns line up
        for (j = 0; j < N; j++) begin : g_deskew
            wsa_delay #(.W(DSW), .D(N - 1 - j)) u_dsk (
                .clk   (clk),
                .rst_n (rst_n),
                .adv   (adv),
                .d     ({pe_v[N-1][j], pe_acc[N-1][j]}),
                .q     (ds_q[j])
            );
            assign col_v[j]             = ds_q[j][AW];
            assign out_sum[j*AW +: AW]  = ds_q[j][AW-1:0];
            assign unused_bottom[j]     = ^pe_w[N-1][j];
        end
    endgenerate

    assign out_vld = &col_v;

endmodule

// File: rtl/wsa_array_chk.sv
`timescale 1ns/1ps
module wsa_array_chk #(
    parameter int N  = 4,
    parameter int AW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            wset,
    input logic            w_loaded,
    input logic            out_vld,
    input logic [N*AW-1:0] out_sum
);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(out_sum) && $stable(out_vld) && $stable(w_loaded));

    // R9
    shift_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wset) |=> $stable(out_sum) && $stable(out_vld));

    // R3
    load_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_loaded) |-> $past(en && wset));

    // R3
    load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(w_loaded) |-> $past(en && wset));

endmodule

bind wsa_array wsa_array_chk #(.N(N), .AW(AW)) u_wsa_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .wset     (wset),
    .w_loaded (w_loaded),
    .out_vld  (out_vld),
    .out_sum  (out_sum)
);

// File: tb/test_wsa_array.sv
`timescale 1ns/1ps
module test_wsa_array;

    localparam int N  = 4;
    localparam int DW = 8;
    localparam int AW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic            wset = 1'b0;
    logic            act_vld = 1'b0;
    logic [N*DW-1:0] wt_in = '0;
    logic [N*DW-1:0] act_in = '0;
    logic            w_loaded;
    logic            out_vld;
    logic [N*AW-1:0] out_sum;

    always #10 clk = ~clk;

    wsa_array #(.N(N), .DW(DW), .AW(AW)) i_wsa_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .wset     (wset),
        .wt_in    (wt_in),
        .act_vld  (act_vld),
        .act_in   (act_in),
        .w_loaded (w_loaded),
        .out_vld  (out_vld),
        .out_sum  (out_sum)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    logic [DW-1:0]   wm [N][N];
    int              ld_st  = 0;   // 0 empty, 1 filling, 2 full
    int              ld_cnt = 0;
    logic [N*AW-1:0] exp_q [$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [N*AW-1:0] calc(input logic [N*DW-1:0] a);
        logic [N*AW-1:0] r;
        for (int c = 0; c < N; c++) begin
            int s = 0;
            for (int k = 0; k < N; k++)
                s += int'($signed(a[k*DW +: DW])) * int'($signed(wm[k][c]));
            r[c*AW +: AW] = AW'(s);
        end
        return r;
    endfunction

    function automatic logic [N*DW-1:0] rnd_vec();
        logic [N*DW-1:0] r;
        for (int i = 0; i < N; i++) r[i*DW +: DW] = DW'($urandom);
        return r;
    endfunction

    // Drive one cycle at a falling edge, update the model, sample at the next falling edge
    task automatic cyc(input bit e, input bit ws, input bit v,
                       input logic [N*DW-1:0] a, input logic [N*DW-1:0] w);
        logic [N*AW-1:0] ps;
        logic            pv;
        en = e; wset = ws; act_vld = v; act_in = a; wt_in = w;
        ps = out_sum;
        pv = out_vld;
        if (e && !ws && v && ld_st == 2) exp_q.push_back(calc(a));
        if (e && ws) begin
            for (int r = N - 1; r > 0; r--)
                for (int c = 0; c < N; c++) wm[r][c] = wm[r-1][c];
            for (int c = 0; c < N; c++) wm[0][c] = w[c*DW +: DW];
            if (ld_st != 1) begin
                ld_cnt = 1;
                ld_st  = (N == 1) ? 2 : 1;
            end else begin
                ld_cnt++;
                if (ld_cnt == N) ld_st = 2;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R3 w_loaded", 64'(w_loaded), 64'(ld_st == 2));
        if (!e) begin
            chk("R8 sums hold", 64'(out_sum), 64'(ps));
            chk("R8 valid hold", 64'(out_vld), 64'(pv));
        end else if (ws) begin
            chk("R9 sums hold", 64'(out_sum), 64'(ps));
            chk("R9 valid hold", 64'(out_vld), 64'(pv));
        end else if (out_vld) begin
            if (exp_q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL R4 unexpected vector: actual %0h expected none", out_sum);
            end else begin
                chk("R5 column sums", 64'(out_sum), 64'(exp_q.pop_front()));
            end
        end
    endtask

    task automatic load_w(input logic [N*DW-1:0] rows [N], input bit noise);
        for (int s = 0; s < N; s++)
            cyc(1'b1, 1'b1, noise, rnd_vec(), rows[N-1-s]);
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        logic [N*DW-1:0] rows [N];
        void'($urandom(32'd2024));
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) wm[r][c] = '0;

        // R1 reset values
        repeat (3) @(negedge clk);
        chk("R1 out_vld", 64'(out_vld), 64'd0);
        chk("R1 w_loaded", 64'(w_loaded), 64'd0);
        chk("R1 out_sum", 64'(out_sum), 64'd0);
        rst_n = 1'b1;

        // R4 vectors before any weights are ignored
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1, rnd_vec(), '0);
        drain(2 * N);

        // R3 partial load keeps w_loaded low and vectors ignored (R4)
        cyc(1'b1, 1'b1, 1'b0, '0, rnd_vec());
        cyc(1'b1, 1'b1, 1'b1, rnd_vec(), rnd_vec());
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b1, rnd_vec(), '0);
        drain(2 * N);
        for (int i = 0; i < N - 2; i++) cyc(1'b1, 1'b1, 1'b0, '0, rnd_vec());

        // R7 latency of one vector, all columns together
        cyc(1'b1, 1'b0, 1'b1, rnd_vec(), '0);
        for (int i = 1; i <= 2 * N - 1; i++) begin
            chk("R7 out_vld timing", 64'(out_vld), 64'(i == 2 * N - 1));
            if (i < 2 * N - 1) cyc(1'b1, 1'b0, 1'b0, '0, '0);
        end
        drain(N);

        // R5 R8 random stream with stalls and blocked shift requests
        for (int i = 0; i < 150; i++) begin
            int r = int'($urandom % 10);
            if (r < 1)      cyc(1'b0, 1'b1, 1'b1, rnd_vec(), rnd_vec());
            else if (r < 2) cyc(1'b0, 1'b0, 1'b1, rnd_vec(), rnd_vec());
            else            cyc(1'b1, 1'b0, ($urandom % 10) < 7, rnd_vec(), rnd_vec());
        end
        drain(3 * N);

        // R6 wrap: weights and activations at the negative limit
        for (int r = 0; r < N; r++) rows[r] = {N{8'h80}};
        load_w(rows, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, {N{8'h80}}, '0);
        drain(2 * N - 2);
        chk("R6 wrap to zero valid", 64'(out_vld), 64'd1);
        chk("R6 wrap to zero", 64'(out_sum), 64'h0);
        cyc(1'b1, 1'b0, 1'b1, {N{8'h7f}}, '0);
        drain(2 * N - 2);
        chk("R6 wrap negative", 64'(out_sum), 64'h0200020002000200);
        drain(N);

        // R2 R3 reload with random weights while full, then R10 burst
        for (int r = 0; r < N; r++) rows[r] = rnd_vec();
        load_w(rows, 1'b1);
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b1, rnd_vec(), '0);
        for (int i = 0; i < 100; i++) begin
            int r = int'($urandom % 8);
            if (r < 1) cyc(1'b0, 1'b1, 1'b1, rnd_vec(), rnd_vec());
            else       cyc(r != 1, 1'b0, ($urandom % 4) != 0, rnd_vec(), rnd_vec());
        end
        drain(3 * N);
        chk("R10 all vectors emerged", 64'(exp_q.size()), 64'd0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule